// File: doc/BRIEF.md
# Overhead orderwire and data-channel serial output

This block sits on the receive side of a byte-wide synchronous optical line after descrambling. While a frame passes, it collects the fourteen orderwire and data-communications overhead bytes from that frame. The framer marks each such byte with a slot code. When the first framing byte of the following frame arrives, the collected set is shifted out on a three-wire serial port. The port has a serial clock, serial data and a frame pulse.

The serial clock is the byte clock divided by a power of two. It runs without pause. A division of 16 suits the 19.44 MHz byte rate and a division of 64 suits the 77.76 MHz rate; both give 1.215 MHz. Bits change on the falling edge of the serial clock, so a receiver samples them on the rising edge. The 112 bits of a frame leave back to back. The port is idle for the rest of each 125 µs frame, roughly a quarter of it.

Captured bytes enter on a valid-qualified stream with no ready signal. The overhead bytes come at fixed positions in the line signal, which cannot be paused, so there is no back-pressure on either side. The receiver of the serial port has no means to stall it either. Two byte banks let one frame be collected while the previous one is shifted. A frame start that arrives while a shift is still running abandons the rest of that shift. The freshly completed frame is then sent instead.

Top module: `ohdcc_serializer`

## Requirements
- R1: A capture with `cap_valid` high stores `cap_byte` in the slot named by `cap_slot` for the frame being collected. The slot codes are 0 for E1, 1 to 12 for D1 to D12, and 13 for E2. Codes 14 and 15 are ignored. When a slot is written twice in one frame, the last write wins.
- R2: `ser_clk` is low out of reset and toggles every 2^(DIV_LOG2-1) byte clocks without a break. Its rising edges are therefore exactly 2^DIV_LOG2 byte clocks apart.
- R3: The first `frame_start` after reset produces no output, because no complete frame has been collected yet. No frame pulse appears until the second `frame_start`.
- R4: Each later `frame_start` starts the transfer of the bytes collected since the previous `frame_start`. The frame pulse is first seen high between 2 and 2^DIV_LOG2+1 byte clocks after the clock edge that samples `frame_start`.
- R5: A transfer sends slots 0 to 13 in that order, each most significant bit first. All 112 bits are sent on consecutive serial clock periods. `ser_data` changes only when `ser_clk` falls, or in the cycle after a `frame_start`.
- R6: `ser_fp` is high during the first bit of a transfer only, which is the most significant bit of slot 0. It rises exactly once per transfer, together with a falling edge of `ser_clk`.
- R7: Outside a transfer, and during reset, `ser_data` and `ser_fp` are low.
- R8: A slot not written during a frame is sent as 0x00. A capture sampled in the same cycle as `frame_start` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe on the first framing byte of a frame |
| cap_valid | input | 1 | Qualifies `cap_slot` and `cap_byte` |
| cap_slot | input | 4 | Overhead slot code (0 E1, 1..12 D1..D12, 13 E2) |
| cap_byte | input | 8 | Descrambled overhead byte |
| ser_clk | output | 1 | Continuous divided serial clock |
| ser_data | output | 1 | Serial data, most significant bit first |
| ser_fp | output | 1 | Frame pulse on the first bit of slot 0 |

## Verification
The bench builds the block with DIV_LOG2 = 2, a serial period of four byte clocks, and a frame of 600 byte clocks. A whole transfer and its idle gap therefore fit in a few hundred cycles, so five frames can be run in one short pass. These include an unprimed first frame, reordered and repeated captures, out-of-range codes, a capture that coincides with a frame start, and an empty frame. The small divider still has a distinct falling and rising half, so the edge alignment of data and frame pulse, and the start-up latency window, are checked exactly as at the full divisions.

// File: rtl/ohdcc_pkg.sv
package ohdcc_pkg;
  localparam int unsigned SLOTS          = 14;
  localparam int unsigned SLOT_W         = $clog2(SLOTS);
  localparam int unsigned BITS_PER_FRAME = SLOTS * 8;
  localparam int unsigned BIT_CNT_W      = $clog2(BITS_PER_FRAME);

  typedef logic [7:0]        oh_byte_t;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/ohdcc_clkdiv.sv
module ohdcc_clkdiv #(
  parameter int unsigned DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ser_clk,
  output logic tick
);
  logic [DIV_LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // Top bit is the serial clock; the last count of a period is the bit boundary.
  assign ser_clk = cnt[DIV_LOG2-1];
  assign tick    = &cnt;
endmodule

// File: rtl/ohdcc_bank.sv
module ohdcc_bank
  import ohdcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     swap,
  input  logic     wr_en,
  input  slot_t    wr_slot,
  input  oh_byte_t wr_byte,
  input  slot_t    rd_slot,
  output oh_byte_t rd_byte
);
  localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);

  oh_byte_t mem [2][SLOTS];
  logic     wsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < SLOTS; s++)
          mem[b][s] <= '0;
    end else if (swap) begin
      // The bank that was being read becomes the fresh capture bank.
      wsel <= ~wsel;
      for (int s = 0; s < SLOTS; s++)
        mem[~wsel][s] <= '0;
    end else if (wr_en && (wr_slot <= LAST_SLOT)) begin
      mem[wsel][wr_slot] <= wr_byte;
    end
  end

  assign rd_byte = mem[~wsel][rd_slot];
endmodule

// File: rtl/ohdcc_shifter.sv
module ohdcc_shifter
  import ohdcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     frame_start,
  input  oh_byte_t rd_byte,
  output slot_t    rd_slot,
  output logic     busy,
  output logic     ser_data,
  output logic     ser_fp
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BITS_PER_FRAME - 1);

  logic [BIT_CNT_W-1:0] bitcnt;
  logic                 primed;
  logic                 pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      primed <= 1'b0;
      pend   <= 1'b0;
      busy   <= 1'b0;
    end else if (frame_start) begin
      busy   <= 1'b0;
      pend   <= primed;
      primed <= 1'b1;
    end else if (tick) begin
      if (pend) begin
        pend   <= 1'b0;
        busy   <= 1'b1;
        bitcnt <= '0;
      end else if (busy) begin
        if (bitcnt == LAST_BIT) busy <= 1'b0;
        else                    bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  assign rd_slot  = slot_t'(bitcnt >> 3);
  assign ser_data = busy & rd_byte[~bitcnt[2:0]];
  assign ser_fp   = busy & (bitcnt == '0);
endmodule

// File: rtl/ohdcc_serializer.sv
module ohdcc_serializer
  import ohdcc_pkg::*;
#(
  parameter int unsigned DIV_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       cap_valid,
  input  logic [3:0] cap_slot,
  input  logic [7:0] cap_byte,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_fp
);
  logic     tick;
  logic     busy;
  slot_t    rd_slot;
  oh_byte_t rd_byte;

  ohdcc_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_clk (ser_clk),
    .tick    (tick)
  );

  ohdcc_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .swap    (frame_start),
    .wr_en   (cap_valid),
    .wr_slot (slot_t'(cap_slot)),
    .wr_byte (cap_byte),
    .rd_slot (rd_slot),
    .rd_byte (rd_byte)
  );

  ohdcc_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .frame_start (frame_start),
    .rd_byte     (rd_byte),
    .rd_slot     (rd_slot),
    .busy        (busy),
    .ser_data    (ser_data),
    .ser_fp      (ser_fp)
  );
endmodule

// File: rtl/ohdcc_checker.sv
module ohdcc_checker #(
  parameter int unsigned DIV_LOG2 = 4
) (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_fp
);
  localparam logic [DIV_LOG2-1:0] HALF_M1 = DIV_LOG2'((1 << (DIV_LOG2 - 1)) - 1);

  logic [DIV_LOG2-1:0] hcnt;
  logic                sclk_q;
  logic                fp_q;
  logic                fp_seen;
  logic [1:0]          fs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt    <= '1;
      sclk_q  <= 1'b0;
      fp_q    <= 1'b0;
      fp_seen <= 1'b0;
      fs_cnt  <= '0;
    end else begin
      sclk_q <= ser_clk;
      fp_q   <= ser_fp;
      hcnt   <= (ser_clk != sclk_q) ? '0 : hcnt + 1'b1;
      if (frame_start && fs_cnt != 2'd2) fs_cnt <= fs_cnt + 1'b1;
      if (frame_start)             fp_seen <= 1'b0;
      else if (ser_fp && !fp_q)    fp_seen <= 1'b1;
    end
  end

  // R2: the serial clock toggles exactly every half period
  a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk != sclk_q) == (hcnt == HALF_M1));

  // R3: no frame pulse before two frame starts
  a_r3_unprimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_fp && !fp_q) |-> (fs_cnt == 2'd2));

  // R5: data moves only with a falling serial clock or after a frame start
  a_r5_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ser_data) && !$past(frame_start)) |-> $fell(ser_clk));

  // R6: pulse rises with a falling serial clock, once per frame
  a_r6_fp_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_fp) |-> $fell(ser_clk));

  a_r6_fp_once: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_fp && !fp_q) |-> !fp_seen);
endmodule

bind ohdcc_serializer ohdcc_checker #(.DIV_LOG2(DIV_LOG2)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .ser_clk     (ser_clk),
  .ser_data    (ser_data),
  .ser_fp      (ser_fp)
);

// File: tb/ohdcc_serializer_test.sv
module ohdcc_serializer_test;
  localparam int DIVL  = 2;
  localparam int DIV   = 1 << DIVL;
  localparam int FRAME = 600;
  localparam int NBITS = 112;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       cap_valid = 1'b0;
  logic [3:0] cap_slot = '0;
  logic [7:0] cap_byte = '0;
  logic       ser_clk, ser_data, ser_fp;

  always #4 clk = ~clk;

  ohdcc_serializer #(.DIV_LOG2(DIVL)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cap_valid(cap_valid), .cap_slot(cap_slot), .cap_byte(cap_byte),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_fp(ser_fp)
  );

  typedef struct { logic d; logic fp; string tag; } exp_t;
  exp_t q[$];

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  int   cyc    = 0;
  logic [7:0] model [14];
  bit         wrote [14];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < 14; s++) begin
      model[s] = 8'h00;
      wrote[s] = 1'b0;
    end
  endtask

  task automatic push_frame();
    for (int s = 0; s < 14; s++)
      for (int b = 7; b >= 0; b--)
        q.push_back('{model[s][b], (s == 0 && b == 7), wrote[s] ? "R1/R5" : "R8"});
  endtask

  // Frame start with a coincident capture to slot 0 that must be dropped (R8).
  task automatic start_frame(input bit expect_out);
    bit seen;
    int at;
    @(negedge clk);
    frame_start = 1'b1;
    cap_valid   = 1'b1;
    cap_slot    = 4'd0;
    cap_byte    = 8'hFF;
    if (expect_out) push_frame();
    clear_model();
    @(negedge clk);
    frame_start = 1'b0;
    cap_valid   = 1'b0;
    seen = 1'b0;
    at   = 0;
    for (int k = 1; k <= DIV + 2; k++) begin
      if (ser_fp && !seen) begin seen = 1'b1; at = k; end
      if (k < DIV + 2) @(negedge clk);
    end
    if (expect_out)
      check(seen && at >= 2 && at <= DIV + 1, "R4", "pulse latency", at, 2);
    else
      check(!seen, "R3", "pulse after first frame start", int'(seen), 0);
  endtask

  task automatic write(input int slot, input logic [7:0] val);
    @(negedge clk);
    cap_valid = 1'b1;
    cap_slot  = 4'(slot);
    cap_byte  = val;
    if (slot < 14) begin model[slot] = val; wrote[slot] = 1'b1; end
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic wait_frame_end(input int t0);
    while (cyc < t0 + FRAME) @(negedge clk);
  endtask

  // Monitor: pops expected bits at each rising serial clock edge.
  initial begin
    logic prev = 1'b0;
    int   last_rise = -1;
    int   nleft = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (ser_clk && !prev) begin
          if (last_rise >= 0)
            check(cyc - last_rise == DIV, "R2", "serial clock period", cyc - last_rise, DIV);
          last_rise = cyc;
          if (nleft == 0) begin
            if (ser_fp) begin
              if (q.size() == 0) check(1'b0, "R3", "unexpected frame pulse", 1, 0);
              else nleft = NBITS;
            end else begin
              check(!ser_data, "R7", "idle data", int'(ser_data), 0);
            end
          end
          if (nleft > 0) begin
            e = q.pop_front();
            check(ser_fp == e.fp, "R6", "frame pulse bit", int'(ser_fp), int'(e.fp));
            check(ser_data == e.d, e.tag, "serial data bit", int'(ser_data), int'(e.d));
            nleft--;
          end
        end
        prev = ser_clk;
      end
    end
  end

  initial begin
    int t0;
    clear_model();
    repeat (3) @(negedge clk);
    check(ser_clk == 1'b0, "R2", "clock low in reset", int'(ser_clk), 0);
    check(ser_data == 1'b0 && ser_fp == 1'b0, "R7", "outputs low in reset",
          int'({ser_data, ser_fp}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Frame 0: unprimed, collect all slots
    t0 = cyc;
    start_frame(1'b0);
    for (int s = 0; s < 14; s++) write(s, 8'h3C ^ 8'(s * 23));
    wait_frame_end(t0);

    // Frame 1: send frame 0; collect reversed, skip slot 5, repeat slot 3, bad codes
    t0 = cyc;
    start_frame(1'b1);
    for (int s = 13; s >= 1; s--) if (s != 5) write(s, 8'hA5 + 8'(s * 3));
    write(3, 8'h81);
    write(14, 8'hFF);
    write(15, 8'h7E);
    wait_frame_end(t0);

    // Frame 2: send frame 1; collect odd slots only
    t0 = cyc;
    start_frame(1'b1);
    for (int s = 1; s < 14; s += 2) write(s, {4'(s), ~4'(s)});
    wait_frame_end(t0);

    // Frame 3: send frame 2; collect nothing
    t0 = cyc;
    start_frame(1'b1);
    wait_frame_end(t0);

    // Frame 4: send the empty frame 3 (all zeros, pulse still present)
    t0 = cyc;
    start_frame(1'b1);
    wait_frame_end(t0);

    check(q.size() == 0, "R4", "bits left undelivered", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule